// File: doc/BRIEF.md
# Vector Memory Address Generator

This block turns one vector load or store into a stream of element addresses, one per accepted cycle. A command carries an addressing mode, a base address, a stride, a runtime element count and a strip-mining enable. Four modes are offered: unit stride at a fixed element size of 8 bytes, constant stride with a byte distance taken from a scalar operand, indexed access where each address is the base plus an offset from an index stream, and a generated-index mode where the index for element g is g times the stride operand, so no index stream is consumed.

With strip mining on, the runtime count may be longer than the maximum vector length (MVL, 64 by default). The sequencer splits it into chunks: the first chunk runs the odd remainder (count mod MVL) and every later chunk runs a full MVL. When the remainder is zero, the empty first chunk is skipped and the first chunk is a full MVL. With strip mining off, the count is written straight to the vector length and clamped to MVL. Every request reports its element number within the chunk, the current chunk length, a chunk-end flag and a final-element flag. Addresses run on across chunk boundaries.

Top module: `vec_addr_gen`

## Requirements
- R1: After reset `busy`, `req_valid` and `idx_ready` are 0.
- R2: Mode 0 (unit stride): the request for overall element g carries address base + 8·g, modulo 2^AW.
- R3: Mode 1 (constant stride): the request for overall element g carries address base + g·stride, modulo 2^AW. The stride is an unsigned byte distance, so a large value wraps and acts as a negative step.
- R4: Mode 2 (indexed): `req_valid` equals `busy` AND `idx_valid`. The address is base + `idx_data`. `idx_ready` equals `busy` AND `req_ready`, so exactly one index is consumed per accepted request.
- R5: Mode 3 (generated index): the address is base + g·stride and `idx_ready` stays 0.
- R6: With `start_strip`=1, the first chunk length (`req_chunk_vl`) is n mod MVL, or MVL when that remainder is 0. Every later chunk is MVL long. The total number of requests is n.
- R7: With `start_strip`=0, exactly min(n, MVL) requests are issued in a single chunk.
- R8: A command with n = 0 issues no request and `busy` never rises.
- R9: A request that is valid but not accepted keeps its element number and chunk length in the next cycle. In the non-indexed modes it also keeps `req_valid` and its address. The generator moves on only when `req_valid` and `req_ready` are both 1.
- R10: `req_last` is 1 only on the final request of the command. In the cycle after that request is accepted, `busy` and `req_valid` are 0. A `start` seen while `busy` is 1 is ignored.
- R11: `req_elem` counts 0 to `req_chunk_vl`−1 inside each chunk. `req_chunk_end` is 1 exactly on element `req_chunk_vl`−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Command strobe, taken only when idle |
| start_mode | input | 2 | 0 unit, 1 stride, 2 indexed, 3 generated index |
| start_base | input | AW | Base byte address |
| start_stride | input | AW | Stride in bytes (modes 1 and 3) |
| start_len | input | LW | Runtime element count n |
| start_strip | input | 1 | 1 = strip-mine n into chunks; 0 = clamp n to MVL |
| idx_valid | input | 1 | Index stream element available |
| idx_data | input | AW | Index byte offset |
| idx_ready | output | 1 | Index element consumed this cycle |
| req_valid | output | 1 | Address request valid |
| req_ready | input | 1 | Address request accepted |
| req_addr | output | AW | Element byte address |
| req_elem | output | EW | Element number within the chunk |
| req_chunk_vl | output | VLW | Length of the current chunk |
| req_chunk_end | output | 1 | Last element of the chunk |
| req_last | output | 1 | Last element of the command |
| busy | output | 1 | Command in progress |

## Verification
The bench runs each mode with random bases, strides and back-pressure, and compares each address with the formula for its mode. This separates an accumulation error from a mode-selection error. Counts of 0, 1, just under, exactly at and just over MVL, and multiples of MVL, test the remainder-first chunking and the skip of the empty first chunk against the clamped single-chunk path. Indexed runs gap the index stream so that valid gating and index consumption are seen apart from address arithmetic. A start pulse injected mid-command must leave the running sequence unchanged.

// File: rtl/vag_pkg.sv
package vag_pkg;
    typedef enum logic [1:0] {
        AM_UNIT   = 2'd0,
        AM_STRIDE = 2'd1,
        AM_INDEX  = 2'd2,
        AM_RAMP   = 2'd3
    } addr_mode_e;
endpackage

// File: rtl/vag_strip_seq.sv
module vag_strip_seq #(
    parameter int MVL = 64,
    parameter int LW  = 16,
    parameter int VLW = $clog2(MVL + 1),
    parameter int EW  = $clog2(MVL)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [LW-1:0]  load_len,
    input  logic           load_strip,
    input  logic           advance,
    output logic           active,
    output logic [VLW-1:0] vl,
    output logic [EW-1:0]  elem,
    output logic           chunk_end,
    output logic           final_elem
);
    localparam logic [LW-1:0]  MVL_L = LW'(MVL);
    localparam logic [VLW-1:0] MVL_V = VLW'(MVL);

    typedef struct packed {
        logic           active;
        logic [VLW-1:0] vl;
        logic [EW-1:0]  elem;
        logic [LW-1:0]  rem;
    } seq_t;

    seq_t s_d, s_q;
    logic [LW-1:0] mod_w, first_w, rest_w;

    assign mod_w = load_len % MVL_L;

    always_comb begin
        s_d = s_q;
        if (load_strip) begin
            first_w = (mod_w == '0) ? MVL_L : mod_w;
            rest_w  = load_len - first_w;
        end else begin
            first_w = (load_len > MVL_L) ? MVL_L : load_len;
            rest_w  = '0;
        end
        if (load && !s_q.active) begin
            if (load_len != '0) begin
                s_d.active = 1'b1;
                s_d.vl     = VLW'(first_w);
                s_d.elem   = '0;
                s_d.rem    = rest_w;
            end
        end else if (advance && s_q.active) begin
            if (VLW'(s_q.elem) == s_q.vl - 1'b1) begin
                s_d.elem = '0;
                if (s_q.rem == '0) begin
                    s_d.active = 1'b0;
                end else begin
                    s_d.vl  = MVL_V;
                    s_d.rem = s_q.rem - MVL_L;
                end
            end else begin
                s_d.elem = s_q.elem + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active     = s_q.active;
    assign vl         = s_q.vl;
    assign elem       = s_q.elem;
    assign chunk_end  = s_q.active && (VLW'(s_q.elem) == s_q.vl - 1'b1);
    assign final_elem = chunk_end && (s_q.rem == '0);

    assert_vl_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (vl != '0) && (vl <= MVL_V));
    assert_elem_in_chunk_R11: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (VLW'(elem) < vl));
    assert_rem_full_chunks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> ((s_q.rem % MVL_L) == '0));
    assert_final_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && final_elem) |=> !active);
    assert_later_chunk_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && chunk_end && !final_elem) |=> (vl == MVL_V) && (elem == '0));
endmodule

// File: rtl/vag_addr_unit.sv
module vag_addr_unit
    import vag_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  addr_mode_e    load_mode,
    input  logic [AW-1:0] load_base,
    input  logic [AW-1:0] load_step,
    input  logic          advance,
    input  logic [AW-1:0] idx_data,
    output addr_mode_e    mode,
    output logic [AW-1:0] addr
);
    typedef struct packed {
        addr_mode_e    mode;
        logic [AW-1:0] base;
        logic [AW-1:0] step;
        logic [AW-1:0] off;
    } au_t;

    au_t a_d, a_q;

    always_comb begin
        a_d = a_q;
        if (load) begin
            a_d.mode = load_mode;
            a_d.base = load_base;
            a_d.step = load_step;
            a_d.off  = '0;
        end else if (advance) begin
            a_d.off = a_q.off + a_q.step;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign mode = a_q.mode;
    assign addr = (a_q.mode == AM_INDEX) ? (a_q.base + idx_data) : (a_q.base + a_q.off);

    assert_first_at_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_mode != AM_INDEX) |=> (addr == $past(load_base)));
    assert_idle_offset_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !advance && mode != AM_INDEX) |=> $stable(addr));
endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen
    import vag_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LW    = 16,
    parameter int MVL   = 64,
    parameter int ESIZE = 8,
    parameter int VLW   = $clog2(MVL + 1),
    parameter int EW    = $clog2(MVL)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [1:0]     start_mode,
    input  logic [AW-1:0]  start_base,
    input  logic [AW-1:0]  start_stride,
    input  logic [LW-1:0]  start_len,
    input  logic           start_strip,
    input  logic           idx_valid,
    input  logic [AW-1:0]  idx_data,
    output logic           idx_ready,
    output logic           req_valid,
    input  logic           req_ready,
    output logic [AW-1:0]  req_addr,
    output logic [EW-1:0]  req_elem,
    output logic [VLW-1:0] req_chunk_vl,
    output logic           req_chunk_end,
    output logic           req_last,
    output logic           busy
);
    addr_mode_e    cmd_mode, cur_mode;
    logic          take_cmd, accept, seq_active;
    logic [AW-1:0] cmd_step;

    assign cmd_mode = addr_mode_e'(start_mode);
    assign take_cmd = start && !seq_active;
    assign cmd_step = (cmd_mode == AM_UNIT) ? AW'(ESIZE) : start_stride;

    assign busy      = seq_active;
    assign req_valid = seq_active && ((cur_mode != AM_INDEX) || idx_valid);
    assign accept    = req_valid && req_ready;
    assign idx_ready = seq_active && (cur_mode == AM_INDEX) && req_ready;

    vag_strip_seq #(.MVL(MVL), .LW(LW), .VLW(VLW), .EW(EW)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (take_cmd),
        .load_len   (start_len),
        .load_strip (start_strip),
        .advance    (accept),
        .active     (seq_active),
        .vl         (req_chunk_vl),
        .elem       (req_elem),
        .chunk_end  (req_chunk_end),
        .final_elem (req_last)
    );

    vag_addr_unit #(.AW(AW)) i_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take_cmd),
        .load_mode (cmd_mode),
        .load_base (start_base),
        .load_step (cmd_step),
        .advance   (accept),
        .idx_data  (idx_data),
        .mode      (cur_mode),
        .addr      (req_addr)
    );

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> $stable(req_elem) && $stable(req_chunk_vl));
    assert_stall_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && cur_mode != AM_INDEX) |=> req_valid && $stable(req_addr));
    assert_idx_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_ready && idx_valid) |-> (req_valid && req_ready));
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_last) |=> !busy && !req_valid);
    assert_zero_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && start_len == '0) |=> !busy);
    assert_last_is_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_last |-> req_chunk_end);
endmodule

// File: tb/test_vec_addr_gen.sv
module test_vec_addr_gen;
    localparam int AW = 32, LW = 16, MVL = 64;
    localparam int VLW = $clog2(MVL + 1), EW = $clog2(MVL);

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, start_strip = 1'b0;
    logic [1:0] start_mode = '0;
    logic [AW-1:0] start_base = '0, start_stride = '0, idx_data = '0;
    logic [LW-1:0] start_len = '0;
    logic idx_valid = 1'b0, req_ready = 1'b0;
    logic idx_ready, req_valid, req_chunk_end, req_last, busy;
    logic [AW-1:0] req_addr;
    logic [EW-1:0] req_elem;
    logic [VLW-1:0] req_chunk_vl;

    int n_tests = 0, n_fail = 0;

    always #2 clk = ~clk;

    vec_addr_gen #(.AW(AW), .LW(LW), .MVL(MVL)) i_vec_addr_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .start_mode(start_mode),
        .start_base(start_base), .start_stride(start_stride), .start_len(start_len),
        .start_strip(start_strip), .idx_valid(idx_valid), .idx_data(idx_data),
        .idx_ready(idx_ready), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_elem(req_elem), .req_chunk_vl(req_chunk_vl),
        .req_chunk_end(req_chunk_end), .req_last(req_last), .busy(busy)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int first_len(input int n, input bit strip);
        if (strip) return (n % MVL == 0) ? MVL : n % MVL;
        return (n > MVL) ? MVL : n;
    endfunction

    function automatic int total_len(input int n, input bit strip);
        if (strip) return n;
        return (n > MVL) ? MVL : n;
    endfunction

    function automatic logic [AW-1:0] exp_addr(input int mode, input logic [AW-1:0] base,
            input logic [AW-1:0] stride, input int g, input logic [AW-1:0] idx);
        case (mode)
            0: return base + AW'(8 * g);
            2: return base + idx;
            default: return base + AW'(g) * stride;
        endcase
    endfunction

    task automatic run_op(input int mode, input logic [AW-1:0] base, input logic [AW-1:0] stride,
            input int n, input bit strip, input int rdy_pct, input int idx_pct, input int poke_at);
        int total, g, e, cvl, guard;
        bit prev_stall;
        logic [AW-1:0] prev_addr;
        @(negedge clk);
        start = 1'b1; start_mode = 2'(mode); start_base = base; start_stride = stride;
        start_len = LW'(n); start_strip = strip;
        @(negedge clk);
        start = 1'b0;
        total = total_len(n, strip);
        if (total == 0) begin
            for (int k = 0; k < 3; k++) begin
                #1;
                chk(!busy && !req_valid, "R8 zero length stays idle", {busy, req_valid}, 0);
                @(negedge clk);
            end
            return;
        end
        g = 0; e = 0; cvl = first_len(n, strip); guard = 0; prev_stall = 0; prev_addr = '0;
        while (g < total && guard < 20000) begin
            guard++;
            req_ready = (($urandom % 100) < rdy_pct);
            idx_valid = (($urandom % 100) < idx_pct);
            idx_data  = $urandom;
            if (poke_at >= 0 && g == poke_at) begin
                start = 1'b1; start_mode = 2'd1; start_base = 32'hDEAD0000;
                start_stride = 32'h40; start_len = 16'd3; start_strip = 1'b0;
            end else start = 1'b0;
            #1;
            if (mode == 2) begin
                chk(req_valid == idx_valid, "R4 valid follows index stream", req_valid, idx_valid);
                chk(idx_ready == req_ready, "R4 index pop on accept", idx_ready, req_ready);
            end else begin
                chk(req_valid, "R9 valid held while busy", req_valid, 1);
                chk(!idx_ready, "R5 no index consumed", idx_ready, 0);
                if (prev_stall)
                    chk(req_addr == prev_addr, "R9 address held on stall", req_addr, prev_addr);
            end
            if (req_valid) begin
                chk(req_addr == exp_addr(mode, base, stride, g, idx_data),
                    (mode == 0) ? "R2 unit address" : (mode == 1) ? "R3 stride address" :
                    (mode == 2) ? "R4 indexed address" : "R5 generated index address",
                    req_addr, exp_addr(mode, base, stride, g, idx_data));
                chk(int'(req_chunk_vl) == cvl, strip ? "R6 chunk length" : "R7 clamped length",
                    req_chunk_vl, cvl);
                chk(int'(req_elem) == e, "R11 element number", req_elem, e);
                chk(req_chunk_end == (e == cvl - 1), "R11 chunk end flag", req_chunk_end, e == cvl - 1);
                chk(req_last == (g == total - 1), "R10 last flag", req_last, g == total - 1);
            end
            prev_stall = req_valid && !req_ready;
            prev_addr  = req_addr;
            if (req_valid && req_ready) begin
                g++;
                if (e == cvl - 1) begin e = 0; cvl = MVL; end
                else e++;
            end
            @(negedge clk);
        end
        start = 1'b0; req_ready = 1'b0; idx_valid = 1'b0;
        chk(g == total, "R6 request count", g, total);
        #1;
        chk(!busy && !req_valid, "R10 idle after last", {busy, req_valid}, 0);
    endtask

    initial begin
        #(4 * 190000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        #1;
        chk(!busy && !req_valid && !idx_ready, "R1 reset state", {busy, req_valid, idx_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // directed corners
        run_op(0, 32'h1000, 0, 0, 1, 100, 100, -1);            // R8
        run_op(0, 32'h1000, 0, 1, 1, 100, 100, -1);            // R2 single
        run_op(0, 32'h2000, 0, 64, 1, 100, 100, -1);           // R6 remainder 0
        run_op(1, 32'h3000, 32'h18, 128, 1, 70, 100, -1);      // R3, R6 two full chunks
        run_op(1, 32'h4000, 32'hFFFF_FFF0, 65, 1, 60, 100, -1); // R3 wrap, R6 1 then 64
        run_op(0, 32'h5000, 0, 100, 0, 80, 100, -1);           // R7 clamp
        run_op(1, 32'h6000, 32'h20, 10, 0, 50, 100, -1);       // R7 short
        run_op(2, 32'h7000, 0, 70, 1, 60, 50, -1);             // R4
        run_op(3, 32'h8000, 32'h10, 67, 1, 60, 50, -1);        // R5
        run_op(0, 32'h9000, 0, 20, 1, 100, 100, 5);            // R10 start ignored when busy
        run_op(0, 32'hA000, 0, 63, 1, 40, 100, -1);            // R6 remainder 63
        // constrained random
        for (int t = 0; t < 30; t++) begin
            run_op(int'($urandom % 4), $urandom, $urandom % 4096, int'($urandom % 200),
                   1'($urandom % 2), 30 + int'($urandom % 70), 40 + int'($urandom % 60), -1);
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule